// File: doc/BRIEF.md
# Programmable Level/Pulse Interrupt Controller

This block collects single-cycle event strobes from a set of sources and turns them into three general-purpose active-low interrupt pins plus one active-low error pin. Each source carries a 2-bit routing code that sends its events to interrupt output 1, 2 or 3. Code 0 points at an output that does not exist, so that source is switched off. Every interrupt output keeps a status register with one bit per source, a mask bit and a mode bit. The mode bit selects between a level interrupt and a fixed-width pulse.

The mask gates only the pin. Status bits keep latching while an output is masked, so a level-mode output whose mask is lifted with bits pending goes active at once. A level-mode pin stays low until the host reads that output's status register, and the read clears the register. A pulse-mode pin goes low for a fixed number of clock cycles, set by a parameter so that it matches one microsecond at the system clock rate. The error pin follows a separate error status register and no mask acts on it. An error bit is set when its condition rises. It clears on a read of the error register or when the condition drops.

The host reads through a simple port: a read enable and a 2-bit selector. The value comes out on the read data bus one clock later.

Top module: `lpic_top`

## Requirements
- R1: A strobe on source e whose routing code (bits 2e+1:2e of `evt_route`) is c = 1, 2 or 3 sets bit e of output c's status register. Routing code 0 sets no status bit and moves no pin.
- R2: After reset every status register is clear, `irq_n` is 3'b111, `err_n` is 1 and `rd_data` is 0.
- R3: In level mode (`irq_pulse_mode` bit k = 0) the unmasked pin `irq_n[k]` (output k+1) goes low at the clock edge that samples the event. It stays low for as long as output k+1's status register is non-zero.
- R4: A read with `rd_en`=1 and `rd_sel` = 1, 2 or 3 returns output 1, 2 or 3's status register on `rd_data` after that edge, and clears the register. `rd_sel` = 0 does the same for the error status register (bits N_ERR-1:0, zero-extended). `rd_data` holds its value when no read is made.
- R5: In pulse mode (bit k = 1) an unmasked event drives `irq_n[k]` low for exactly PULSE_CYCLES clock cycles, starting at the edge that samples it. An event during a pulse restarts the full width.
- R6: A set mask bit keeps its pin high while status bits keep latching. In level mode, clearing the mask with bits pending drives the pin low at the next edge.
- R7: An error status bit is set on a rising edge of its `err_cond` bit. It clears on an error-register read or when that condition goes low. `err_n` is low exactly while any error status bit is set, whatever the mask bits hold.
- R8: An event that arrives in the same cycle as a clearing read of its status register stays latched. The read returns the contents held before that cycle.
- R9: A pulse-mode event latches its status bit like a level-mode event, and a read clears it. A masked pulse-mode event produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_stb | input | N_EVT | One-cycle event strobes, one per source |
| evt_route | input | 2*N_EVT | Routing code per source: 0 off, 1..3 select an output |
| irq_mask | input | 3 | Pin mask per output, bit k for output k+1 |
| irq_pulse_mode | input | 3 | 1 = pulse mode, 0 = level mode, per output |
| err_cond | input | N_ERR | Error condition levels |
| rd_en | input | 1 | Read strobe, clears the selected status register |
| rd_sel | input | 2 | 0 = error status, 1..3 = interrupt output status |
| rd_data | output | max(N_EVT,N_ERR) | Registered read data |
| irq_n | output | 3 | Active-low interrupt pins, bit k = output k+1 |
| err_n | output | 1 | Active-low error pin |

## Verification
The first routing pattern gives each source a different code, and all sources strobe in one cycle. Reading each status register then shows whether events reach the right output and whether code 0 is dropped. A lone level-mode event, held across idle cycles, separates a level output from a pulse output. Two pulse-mode strobes a few cycles apart measure the exact pulse width and show whether a second strobe restarts the count. A masked event followed by an unmask tells pin gating apart from status gating. An event placed in the same cycle as a read tells a safe clear from one that loses the event. For the error pin, a condition held high across a read and a condition that simply drops tell the two ways an error bit clears apart.

// File: rtl/lpic_pkg.sv
package lpic_pkg;
  localparam int NUM_IRQ = 3;

  typedef logic [1:0] route_t;

  typedef enum logic [1:0] {
    SEL_ERR  = 2'd0,
    SEL_IRQ1 = 2'd1,
    SEL_IRQ2 = 2'd2,
    SEL_IRQ3 = 2'd3
  } rd_sel_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lpic_router.sv
module lpic_router
  import lpic_pkg::*;
#(
  parameter int N_EVT = 8
) (
  input  logic [N_EVT-1:0]               evt_i,
  input  logic [2*N_EVT-1:0]             route_i,
  output logic [NUM_IRQ-1:0][N_EVT-1:0]  hit_o
);
  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_out
    for (genvar e = 0; e < N_EVT; e++) begin : g_src
      // code 0 matches no output, so the source is off
      assign hit_o[k][e] = evt_i[e] && (route_i[2*e +: 2] == route_t'(k + 1));
    end
  end
endmodule

// File: rtl/lpic_channel.sv
module lpic_channel #(
  parameter int N_EVT        = 8,
  parameter int PULSE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] hit_i,
  input  logic             clr_i,
  input  logic             mask_i,
  input  logic             pulse_mode_i,
  output logic [N_EVT-1:0] stat_o,
  output logic             irq_n_o
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [N_EVT-1:0] stat_q, stat_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             irq_n_q;
  logic             drive;

  always_comb begin
    // new events win over a clear in the same cycle
    stat_d = (clr_i ? '0 : stat_q) | hit_i;
    if (!pulse_mode_i)
      cnt_d = '0;
    else if ((|hit_i) && !mask_i)
      cnt_d = CW'(PULSE_CYCLES);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = '0;
    drive = pulse_mode_i ? (cnt_d != '0) : (|stat_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      cnt_q   <= '0;
      irq_n_q <= 1'b1;
    end else begin
      stat_q  <= stat_d;
      cnt_q   <= cnt_d;
      irq_n_q <= ~(drive & ~mask_i);
    end
  end

  assign stat_o  = stat_q;
  assign irq_n_o = irq_n_q;

  AST_STAT_KEEP: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));  // R6
  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
    (|hit_i) |=> ((stat_q & $past(hit_i)) == $past(hit_i)));  // R8
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !(|hit_i)) |=> (stat_q == '0));  // R4
  AST_LEVEL_PIN: assert property (@(posedge clk) disable iff (rst)
    (!$past(pulse_mode_i) && !$past(mask_i) && (|stat_q)) |-> !irq_n_q);  // R3
  AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(pulse_mode_i) && (cnt_q == '0)) |-> irq_n_q);  // R5
  AST_MASK_PIN: assert property (@(posedge clk) disable iff (rst)
    $past(mask_i) |-> irq_n_q);  // R6
endmodule

// File: rtl/lpic_err.sv
module lpic_err #(
  parameter int N_ERR = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_ERR-1:0] cond_i,
  input  logic             clr_i,
  output logic [N_ERR-1:0] stat_o,
  output logic             err_n_o
);
  logic [N_ERR-1:0] cond_q, stat_q, stat_d, rise;
  logic             err_n_q;

  always_comb begin
    rise   = cond_i & ~cond_q;
    stat_d = (stat_q & cond_i & {N_ERR{~clr_i}}) | rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q  <= '0;
      stat_q  <= '0;
      err_n_q <= 1'b1;
    end else begin
      cond_q  <= cond_i;
      stat_q  <= stat_d;
      err_n_q <= ~(|stat_d);
    end
  end

  assign stat_o  = stat_q;
  assign err_n_o = err_n_q;

  AST_ERR_NEEDS_COND: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(cond_i)) == '0));  // R7
  AST_ERR_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_i && (rise == '0)) |=> (stat_q == '0));  // R7
  AST_ERR_PIN: assert property (@(posedge clk) disable iff (rst)
    (|stat_q) |-> !err_n_q);  // R7
endmodule

// File: rtl/lpic_top.sv
module lpic_top
  import lpic_pkg::*;
#(
  parameter  int N_EVT        = 8,
  parameter  int N_ERR        = 4,
  parameter  int PULSE_CYCLES = 16,
  localparam int RD_W         = max_int(N_EVT, N_ERR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_EVT-1:0]   evt_stb,
  input  logic [2*N_EVT-1:0] evt_route,
  input  logic [2:0]         irq_mask,
  input  logic [2:0]         irq_pulse_mode,
  input  logic [N_ERR-1:0]   err_cond,
  input  logic               rd_en,
  input  logic [1:0]         rd_sel,
  output logic [RD_W-1:0]    rd_data,
  output logic [2:0]         irq_n,
  output logic               err_n
);
  logic [NUM_IRQ-1:0][N_EVT-1:0] hit, ch_stat;
  logic [N_ERR-1:0]              err_stat;
  logic [RD_W-1:0]               rd_mux, rd_q;
  logic                          err_clr;

  lpic_router #(.N_EVT(N_EVT)) u_router (
    .evt_i   (evt_stb),
    .route_i (evt_route),
    .hit_o   (hit)
  );

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_ch
    logic clr;
    assign clr = rd_en && (rd_sel == 2'(k + 1));
    lpic_channel #(.N_EVT(N_EVT), .PULSE_CYCLES(PULSE_CYCLES)) u_ch (
      .clk          (clk),
      .rst          (rst),
      .hit_i        (hit[k]),
      .clr_i        (clr),
      .mask_i       (irq_mask[k]),
      .pulse_mode_i (irq_pulse_mode[k]),
      .stat_o       (ch_stat[k]),
      .irq_n_o      (irq_n[k])
    );
  end

  assign err_clr = rd_en && (rd_sel == SEL_ERR);

  lpic_err #(.N_ERR(N_ERR)) u_err (
    .clk     (clk),
    .rst     (rst),
    .cond_i  (err_cond),
    .clr_i   (err_clr),
    .stat_o  (err_stat),
    .err_n_o (err_n)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_sel == SEL_ERR)
      rd_mux[N_ERR-1:0] = err_stat;
    else
      rd_mux[N_EVT-1:0] = ch_stat[rd_sel - 2'd1];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));  // R4
endmodule

// File: tb/sim_lpic_top.sv
module sim_lpic_top;
  localparam int NE = 8;
  localparam int NR = 4;
  localparam int PW = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NE-1:0]   evt_stb = '0;
  logic [2*NE-1:0] evt_route = '0;
  logic [2:0]      irq_mask = '0;
  logic [2:0]      irq_pulse_mode = '0;
  logic [NR-1:0]   err_cond = '0;
  logic            rd_en = 1'b0;
  logic [1:0]      rd_sel = '0;
  logic [NE-1:0]   rd_data;
  logic [2:0]      irq_n;
  logic            err_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lpic_top #(.N_EVT(NE), .N_ERR(NR), .PULSE_CYCLES(PW)) u0 (
    .clk(clk), .rst(rst), .evt_stb(evt_stb), .evt_route(evt_route),
    .irq_mask(irq_mask), .irq_pulse_mode(irq_pulse_mode), .err_cond(err_cond),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq_n(irq_n), .err_n(err_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fire(input logic [NE-1:0] m);
    evt_stb = m;
    @(negedge clk);
    evt_stb = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [NE-1:0] d);
    rd_en  = 1'b1;
    rd_sel = sel;
    @(negedge clk);
    rd_en  = 1'b0;
    d      = rd_data;
  endtask

  task automatic set_route(input int e, input logic [1:0] c);
    evt_route[2*e +: 2] = c;
  endtask

  task automatic t_reset();
    logic [NE-1:0] d;
    chk(irq_n == 3'b111, "R2 irq_n", 32'(irq_n), 32'h7);
    chk(err_n == 1'b1, "R2 err_n", 32'(err_n), 32'h1);
    chk(rd_data == '0, "R2 rd_data", 32'(rd_data), 32'h0);
    rd(2'd1, d);
    chk(d == '0, "R2 status1", 32'(d), 32'h0);
  endtask

  task automatic t_route();
    logic [NE-1:0] d;
    for (int e = 0; e < NE; e++) set_route(e, 2'(e % 4));
    irq_pulse_mode = 3'b000;
    fire(8'hFF);
    chk(irq_n == 3'b000, "R1 all pins low", 32'(irq_n), 32'h0);
    rd(2'd1, d);
    chk(d == 8'h22, "R1 status1", 32'(d), 32'h22);
    chk(irq_n == 3'b001, "R4 pin1 released", 32'(irq_n), 32'h1);
    rd(2'd2, d);
    chk(d == 8'h44, "R1 status2", 32'(d), 32'h44);
    rd(2'd3, d);
    chk(d == 8'h88, "R1 status3", 32'(d), 32'h88);
    chk(irq_n == 3'b111, "R4 all released", 32'(irq_n), 32'h7);
    fire(8'h11);  // only code-0 sources
    chk(irq_n == 3'b111, "R1 code0 ignored pins", 32'(irq_n), 32'h7);
    rd(2'd1, d);
    chk(d == 8'h00, "R1 code0 ignored status", 32'(d), 32'h0);
  endtask

  task automatic t_level();
    logic [NE-1:0] d;
    for (int e = 0; e < NE; e++) set_route(e, 2'd2);
    fire(8'h08);
    chk(irq_n == 3'b101, "R3 level low", 32'(irq_n), 32'h5);
    step(5);
    chk(irq_n == 3'b101, "R3 level held", 32'(irq_n), 32'h5);
    rd(2'd2, d);
    chk(d == 8'h08, "R4 read value", 32'(d), 32'h08);
    chk(irq_n == 3'b111, "R3 released by read", 32'(irq_n), 32'h7);
    step(2);
    chk(rd_data == 8'h08, "R4 rd_data holds", 32'(rd_data), 32'h08);
  endtask

  task automatic t_pulse();
    logic [NE-1:0] d;
    set_route(0, 2'd1);
    irq_pulse_mode = 3'b001;
    fire(8'h01);
    chk(irq_n[0] == 1'b0, "R5 pulse start", 32'(irq_n), 32'h6);
    step(PW - 1);
    chk(irq_n[0] == 1'b0, "R5 pulse last cycle", 32'(irq_n), 32'h6);
    step(1);
    chk(irq_n[0] == 1'b1, "R5 pulse end", 32'(irq_n), 32'h7);
    rd(2'd1, d);
    chk(d == 8'h01, "R9 pulse status latched", 32'(d), 32'h01);
    fire(8'h01);
    step(5);
    fire(8'h01);
    step(PW - 1);
    chk(irq_n[0] == 1'b0, "R5 retrigger extends", 32'(irq_n), 32'h6);
    step(1);
    chk(irq_n[0] == 1'b1, "R5 retrigger end", 32'(irq_n), 32'h7);
    irq_mask = 3'b001;
    fire(8'h01);
    step(2);
    chk(irq_n[0] == 1'b1, "R9 masked no pulse", 32'(irq_n), 32'h7);
    rd(2'd1, d);
    chk(d == 8'h01, "R9 masked status", 32'(d), 32'h01);
    irq_mask = 3'b000;
    irq_pulse_mode = 3'b000;
  endtask

  task automatic t_mask();
    logic [NE-1:0] d;
    set_route(7, 2'd3);
    irq_mask = 3'b100;
    fire(8'h80);
    chk(irq_n[2] == 1'b1, "R6 masked pin high", 32'(irq_n), 32'h7);
    step(3);
    chk(irq_n[2] == 1'b1, "R6 masked pin stays high", 32'(irq_n), 32'h7);
    irq_mask = 3'b000;
    step(1);
    chk(irq_n[2] == 1'b0, "R6 unmask fires", 32'(irq_n), 32'h3);
    rd(2'd3, d);
    chk(d == 8'h80, "R6 status latched under mask", 32'(d), 32'h80);
    chk(irq_n == 3'b111, "R6 released", 32'(irq_n), 32'h7);
  endtask

  task automatic t_same_cycle();
    logic [NE-1:0] d;
    set_route(0, 2'd1);
    set_route(1, 2'd1);
    fire(8'h02);
    evt_stb = 8'h01;
    rd(2'd1, d);
    evt_stb = '0;
    chk(d == 8'h02, "R8 read old value", 32'(d), 32'h02);
    chk(irq_n[0] == 1'b0, "R8 pin still low", 32'(irq_n), 32'h6);
    rd(2'd1, d);
    chk(d == 8'h01, "R8 event kept", 32'(d), 32'h01);
  endtask

  task automatic t_err();
    logic [NE-1:0] d;
    irq_mask = 3'b111;
    err_cond = 4'b0001;
    step(1);
    chk(err_n == 1'b0, "R7 error low, unmaskable", 32'(err_n), 32'h0);
    rd(2'd0, d);
    chk(d == 8'h01, "R7 error status read", 32'(d), 32'h01);
    chk(err_n == 1'b1, "R7 cleared by read", 32'(err_n), 32'h1);
    step(2);
    chk(err_n == 1'b1, "R7 held cond no reset", 32'(err_n), 32'h1);
    err_cond = 4'b0000;
    step(1);
    err_cond = 4'b0100;
    step(1);
    chk(err_n == 1'b0, "R7 second error", 32'(err_n), 32'h0);
    err_cond = 4'b0000;
    step(1);
    chk(err_n == 1'b1, "R7 cleared by cond drop", 32'(err_n), 32'h1);
    rd(2'd0, d);
    chk(d == 8'h00, "R7 status empty", 32'(d), 32'h0);
    irq_mask = 3'b000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_route();
    t_level();
    t_pulse();
    t_mask();
    t_same_cycle();
    t_err();
    step(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule